// File: doc/BRIEF.md
# First-Order Sigma-Delta Modulus Selector

This block generates the one-bit modulus-select stream for a fractional-N feedback divider. A static fractional word `frac_word` of `FRAC_W` bits stands for the fraction α = `frac_word` / 2^FRAC_W. On every reference-rate clock that carries `step_en`, the block advances a first-order noise-shaping loop. Its output `mod_sel` tells the divider to divide by N (0) or by N+1 (1). The average of the stream equals α, so the mean divide ratio is N+α. The error between the stream and α is shaped by 1−z⁻¹ and so moves to high offset frequencies, where the phase-locked loop filters it out.

The loop has a delaying integrator of FRAC_W+2 bits in two's complement. On each enabled step the integrator adds α and subtracts 2^FRAC_W whenever the present output is 1. The output is bit FRAC_W of the integrator register, so the output of a step shows in the following cycle. FRAC_W is set by the frequency resolution the synthesizer needs. The reset input is asserted asynchronously. Its release is synchronised to the clock over two stages.

Top module: `frac_mod_sdm1`

## Requirements
- R1: While `rst_n` is low, `mod_sel` is 0 and the integrator is zero, and this takes effect without waiting for a clock edge. After `rst_n` rises, the integrator starts to respond to `step_en` no earlier than the second rising clock edge.
- R2: With `frac_word` = 0, `mod_sel` stays 0 for every step.
- R3: Let k be the number of enabled steps since reset. After those k steps, `mod_sel` equals floor(k·α·2^FRAC_W / 2^FRAC_W) − floor((k−1)·α·2^FRAC_W / 2^FRAC_W), written over `frac_word`, and 0 when k = 0. A value of 1 selects divide-by-N+1 and a value of 0 selects divide-by-N.
- R4: Over the first 2^FRAC_W enabled steps after reset, the number of ones on `mod_sel` is within ±1 of `frac_word`.
- R5: A clock edge with `step_en` low changes neither `mod_sel` nor the integrator.
- R6: The integrator stays within [0, 2^FRAC_W + `frac_word`), so its sign bit is never set and it never wraps.
- R7: When `frac_word` < 2^(FRAC_W−1), two consecutive enabled steps never both produce a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, and its release is synchronised |
| step_en | input | 1 | Advances the loop by one step on this clock edge |
| frac_word | input | FRAC_W | Fractional part α scaled by 2^FRAC_W; held static between resets |
| mod_sel | output | 1 | 1 selects divide-by-N+1, 0 selects divide-by-N |

## Verification
The checker assumes that `frac_word` holds still from the end of reset onward. The bounds on the integrator, the zero-input behaviour and the rule against consecutive ones all depend on a fraction that does not change. The bench changes `frac_word` only while `rst_n` is low. It sweeps every fraction of a four-bit build, and for each one it gates `step_en` in a fixed irregular pattern. This exercises stalled steps against the stream model without ever changing the fraction under a running loop.

// File: rtl/frac_mod_sdm1_pkg.sv
package frac_mod_sdm1_pkg;
  typedef enum logic {
    SEL_DIV_N       = 1'b0,
    SEL_DIV_N_PLUS1 = 1'b1
  } mod_sel_e;

  localparam int unsigned GUARD_BITS = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/frac_mod_sdm1_rst_sync.sv
module frac_mod_sdm1_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/frac_mod_sdm1_integ.sv
module frac_mod_sdm1_integ #(
  parameter int unsigned ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [ACC_W-1:0] delta,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (step_en) acc_d = acc_q + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_mod_sdm1_quant.sv
module frac_mod_sdm1_quant
  import frac_mod_sdm1_pkg::*;
#(
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned ACC_W = FRAC_W + GUARD_BITS
) (
  input  logic [ACC_W-1:0] acc,
  output mod_sel_e         sel,
  output logic [ACC_W-1:0] fb
);
  localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'(1) << FRAC_W;

  always_comb begin
    sel = acc[FRAC_W] ? SEL_DIV_N_PLUS1 : SEL_DIV_N;
    fb  = (sel == SEL_DIV_N_PLUS1) ? FULL_SCALE : '0;
  end
endmodule

// File: rtl/frac_mod_sdm1.sv
module frac_mod_sdm1
  import frac_mod_sdm1_pkg::*;
#(
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [FRAC_W-1:0] frac_word,
  output logic              mod_sel
);
  localparam int unsigned ACC_W = FRAC_W + GUARD_BITS;

  logic             core_rst_n;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] fb;
  logic [ACC_W-1:0] delta;
  mod_sel_e         sel;

  frac_mod_sdm1_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (core_rst_n)
  );

  frac_mod_sdm1_quant #(.FRAC_W(FRAC_W)) u_quant (
    .acc(acc_q),
    .sel(sel),
    .fb (fb)
  );

  always_comb begin
    delta = {{GUARD_BITS{1'b0}}, frac_word} - fb;
  end

  frac_mod_sdm1_integ #(.ACC_W(ACC_W)) u_integ (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .step_en(step_en),
    .delta  (delta),
    .acc_q  (acc_q)
  );

  assign mod_sel = (sel == SEL_DIV_N_PLUS1);
endmodule

// File: rtl/frac_mod_sdm1_chk.sv
module frac_mod_sdm1_chk #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned ACC_W  = FRAC_W + 2
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              step_en,
  input logic [FRAC_W-1:0] frac_word,
  input logic              mod_sel,
  input logic [ACC_W-1:0]  acc_q
);
  localparam logic [ACC_W:0] FULL_SCALE = (ACC_W+1)'(1) << FRAC_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !core_rst_n |-> (acc_q == '0 && !mod_sel));

  assert_zero_frac_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frac_word == '0 && $stable(frac_word) && !mod_sel) |=> !mod_sel);

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    !step_en |=> ($stable(mod_sel) && $stable(acc_q)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    ({1'b0, acc_q} < FULL_SCALE + {{(ACC_W+1-FRAC_W){1'b0}}, frac_word}) && !acc_q[ACC_W-1]);

  assert_no_double_one_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (step_en && mod_sel && !frac_word[FRAC_W-1] && $stable(frac_word)) |=> !mod_sel);
endmodule

bind frac_mod_sdm1 frac_mod_sdm1_chk #(.FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .core_rst_n(core_rst_n),
  .step_en   (step_en),
  .frac_word (frac_word),
  .mod_sel   (mod_sel),
  .acc_q     (acc_q)
);

// File: tb/frac_mod_sdm1_test.sv
module frac_mod_sdm1_test;
  localparam int FW = 4;
  localparam int SCALE = 1 << FW;
  localparam int STEPS = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          step_en = 1'b0;
  logic [FW-1:0] frac_word = '0;
  logic          mod_sel;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  frac_mod_sdm1 #(.FRAC_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .frac_word(frac_word), .mod_sel(mod_sel)
  );

  always #5 clk = ~clk;

  function automatic int expect_bit(int k, int a);
    if (k == 0) return 0;
    return ((k * a) / SCALE) - (((k - 1) * a) / SCALE);
  endfunction

  task automatic check(string req, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, actual, expected, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic run_fraction(int a);
    int k = 0;
    int ones = 0;
    int prev = 0;
    int last = 0;
    step_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    frac_word = FW'(a);
    #1;
    check("R1 async clear", int'(mod_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: steps requested right after release are ignored by the synchroniser
    step_en = 1'b1;
    @(negedge clk);
    check("R1 sync release", int'(mod_sel), 0);
    step_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'(mod_sel), 0);
    for (int c = 0; c < STEPS; c++) begin
      step_en = ((c % 5) != 3);
      @(negedge clk);
      if (step_en) begin
        k++;
        // R3 exact stream, R2 covered when a == 0, R6 via full-scale a
        check(a == 0 ? "R2 zero fraction" : "R3 stream", int'(mod_sel), expect_bit(k, a));
        if (mod_sel) ones++;
        if (a < SCALE / 2 && k > 1) check("R7 no double one", prev & int'(mod_sel), 0);
        if (a == SCALE - 1 && k > 2) check("R6 full scale stream", int'(mod_sel), expect_bit(k, a));
        prev = int'(mod_sel);
        if (k == SCALE) begin
          check("R4 window count", (ones >= a - 1 && ones <= a + 1) ? 1 : 0, 1);
        end
      end else begin
        check("R5 stall hold", int'(mod_sel), last);
      end
      last = int'(mod_sel);
    end
    step_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #2;
    for (int a = 0; a < SCALE; a++) run_fraction(a);
    // R1: asynchronous clear in the middle of a run with a 1 on the output
    run_fraction(SCALE - 1);
    @(negedge clk);
    check("R1 preset output high", int'(mod_sel), 1);
    #2 rst_n = 1'b0;
    #1 check("R1 mid-run async clear", int'(mod_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule